// File: doc/BRIEF.md
# System clock mode controller

This block produces the processor base clock `bclk` from one of three oscillators: a fast main clock, a slow sub clock and an on-chip ring oscillator. A single 8-bit control register, written from a free-running control clock, chooses the source and the division ratio. The same register also starts and stops each oscillator through the `run_o` outputs. Every write is checked against a set of ordering rules. A write that breaks a rule leaves the register untouched and raises a sticky error flag.

A settle counter follows each oscillator. It restarts whenever that oscillator's run output goes low and reports the oscillator stable after a fixed number of control cycles. Source changes go through an interlocked gate per source: each gate opens and closes only while its own clock is low. The divider that follows changes its ratio only at a count wrap. The result is that `bclk` never carries a runt pulse. `mode_o` reports which source actually drives the clock, as seen through synchronizers.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the control register reads 0x01, the error flag is 0, `mode_o` is 1 (medium), `run_o` is 3'b001, and `bclk` runs from the main clock divided by 8. Register layout: bit0 force8, bits2:1 div, bit3 sel_sub, bit4 sel_ring, bit5 main_stop, bit6 sub_en, bit7 ring_on.
- R2: With force8 set and the main clock active, the `bclk` period is 8 main periods, whatever div holds.
- R3: With force8 clear, div selects the ratio: 00 gives /1, 01 gives /2, 10 gives /4 and 11 gives /16. `mode_o` is 0 (high) at /1 and 1 (medium) at any other ratio on main.
- R4: Selecting the sub clock is accepted only if the same write has force8 and sub_en set and the sub clock is stable. `bclk` then equals the sub clock undivided and `mode_o` is 2.
- R5: Selecting the ring oscillator is accepted only if ring_on is set and the ring oscillator is stable, and never together with sel_sub. The ring clock is divided by the same rules as R2 and R3, and `mode_o` is 3.
- R6: main_stop is accepted only while the main clock is neither requested nor active. Once set, `run_o[0]` is 0.
- R7: A return to the main clock is accepted only when main runs and its settle counter has expired.
- R8: A write whose div differs from the current div is rejected unless it keeps force8 set. Such a write leaves the active division unchanged.
- R9: Leaving the main clock for another source is rejected unless force8 is already set in the current register.
- R10: `stab_o[i]` rises exactly N control cycles after the write that raises `run_o[i]`. N is 16 for main, 24 for sub and 8 for ring.
- R11: A rejected write keeps the register unchanged and sets `err_o`. `err_o` stays set until `err_clr`, and later legal writes do not clear it.
- R12: No high or low phase of `bclk` is shorter than half of the fastest source period, including during source switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctl | input | 1 | Free-running control clock for writes and settle counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_main | input | 1 | Main oscillator clock |
| clk_sub | input | 1 | Sub oscillator clock |
| clk_ring | input | 1 | Ring oscillator clock |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| err_clr | input | 1 | Clears the sticky error flag |
| bclk | output | 1 | Base clock |
| run_o | output | 3 | Oscillator run enables {ring, sub, main} |
| stab_o | output | 3 | Oscillator stable flags {ring, sub, main} |
| cfg_o | output | 8 | Current control register |
| err_o | output | 1 | Sticky rule-violation flag |
| mode_o | output | 3 | 0 high, 1 medium, 2 low, 3 ring, 4 switching |

## Verification
`cfg_o` and `err_o` change at the control edge that samples a write. The scoreboard driver therefore queues each expected value just after that edge, and the monitor compares it at the following falling edge. Stable flags are probed one cycle before and exactly at the settle count after the enabling write. Mode and clock checks cross several synchronizers and a divider wrap, so the bench waits a window many times longer than that path before it reads `mode_o` or times three `bclk` edges. A pulse-width monitor watches every `bclk` phase throughout the run.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  typedef struct packed {
    logic       ring_on;
    logic       sub_en;
    logic       main_stop;
    logic       sel_ring;
    logic       sel_sub;
    logic [1:0] div;
    logic       force8;
  } sck_cfg_t;

  localparam int NSRC = 3;
  localparam logic [1:0] SRC_MAIN = 2'd0;
  localparam logic [1:0] SRC_SUB  = 2'd1;
  localparam logic [1:0] SRC_RING = 2'd2;

  typedef enum logic [2:0] {
    MD_HIGH   = 3'd0,
    MD_MED    = 3'd1,
    MD_LOW    = 3'd2,
    MD_RING   = 3'd3,
    MD_SWITCH = 3'd4
  } sck_mode_e;

  localparam sck_cfg_t CFG_RESET = sck_cfg_t'(8'h01);

  function automatic logic [1:0] src_of(sck_cfg_t c);
    if (c.sel_ring)     return SRC_RING;
    else if (c.sel_sub) return SRC_SUB;
    else                return SRC_MAIN;
  endfunction

  // log2 of the effective division ratio
  function automatic logic [2:0] div_log2(sck_cfg_t c);
    if (c.sel_sub && !c.sel_ring) return 3'd0;
    if (c.force8)                 return 3'd3;
    case (c.div)
      2'b00:   return 3'd0;
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/sck_rst_sync.sv
module sck_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/sck_settle.sv
module sck_settle #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic stable_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)            cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign stable_o = (cnt_q == LIM);
endmodule

// File: rtl/sck_glitchless_mux.sv
module sck_glitchless_mux #(
  parameter int N       = 3,
  parameter int RST_SEL = 0
) (
  input  logic [N-1:0] src_clk,
  input  logic [N-1:0] src_rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gate_o,
  output logic         mclk
);
  for (genvar g = 0; g < N; g++) begin : g_leg
    localparam logic [N-1:0] ME = N'(1) << g;
    localparam logic RV = (g == RST_SEL);
    logic s1_q, s2_q, gate_q;
    logic others;

    assign others = |(gate_o & ~ME);

    always_ff @(posedge src_clk[g] or negedge src_rst_n[g]) begin
      if (!src_rst_n[g]) begin
        s1_q <= RV;
        s2_q <= RV;
      end else begin
        s1_q <= req[g] & ~others;
        s2_q <= s1_q;
      end
    end

    always_ff @(negedge src_clk[g] or negedge src_rst_n[g]) begin
      if (!src_rst_n[g]) gate_q <= RV;
      else               gate_q <= s2_q;
    end

    assign gate_o[g] = gate_q;
  end

  assign mclk = |(src_clk & gate_o);
endmodule

// File: rtl/sck_divider.sv
module sck_divider (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic [2:0] log2_i,
  output logic       bclk
);
  logic [2:0] sy1_q, sy2_q;
  logic [3:0] cnt_q, cnt_d, lim_q, lim_d, lim_new;
  logic       en_q, en_d, wrap;

  always_comb begin
    lim_new = 4'((5'd1 << sy2_q) - 5'd1);
    wrap    = (cnt_q >= lim_q);
    cnt_d   = wrap ? 4'd0 : cnt_q + 4'd1;
    lim_d   = wrap ? lim_new : lim_q;
    en_d    = (cnt_d == 4'd0);
  end

  always_ff @(negedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= 3'd3;
      sy2_q <= 3'd3;
      cnt_q <= 4'd0;
      lim_q <= 4'd7;
      en_q  <= 1'b1;
    end else begin
      sy1_q <= log2_i;
      sy2_q <= sy1_q;
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      en_q  <= en_d;
    end
  end

  assign bclk = mclk & en_q;
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int MAIN_SETTLE = 16,
  parameter int SUB_SETTLE  = 24,
  parameter int RING_SETTLE = 8
) (
  input  logic       clk_ctl,
  input  logic       rst_n,
  input  logic       clk_main,
  input  logic       clk_sub,
  input  logic       clk_ring,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       err_clr,
  output logic       bclk,
  output logic [2:0] run_o,
  output logic [2:0] stab_o,
  output logic [7:0] cfg_o,
  output logic       err_o,
  output logic [2:0] mode_o
);
  logic            rst_c_n;
  logic [NSRC-1:0] src_clk, src_rst_n, req, gate_w, act_q1, act_q2;
  sck_cfg_t        cfg_q, cfg_d, nw;
  logic            err_q, err_d, bad;
  logic [1:0]      cur_src, nw_src;
  logic            mclk;
  sck_mode_e       mode;

  assign src_clk = {clk_ring, clk_sub, clk_main};

  sck_rst_sync u_rs_ctl (.clk(clk_ctl), .arst_n(rst_n), .rst_n_o(rst_c_n));

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int LIM = (g == 0) ? MAIN_SETTLE : (g == 1) ? SUB_SETTLE : RING_SETTLE;
    sck_rst_sync u_rs (.clk(src_clk[g]), .arst_n(rst_n), .rst_n_o(src_rst_n[g]));
    sck_settle #(.LIMIT(LIM)) u_settle (
      .clk(clk_ctl), .rst_n(rst_c_n), .run(run_o[g]), .stable_o(stab_o[g])
    );
  end

  // Write rule check
  always_comb begin
    nw      = sck_cfg_t'(wr_data);
    cur_src = src_of(cfg_q);
    nw_src  = src_of(nw);
    bad     = 1'b0;
    if (nw.sel_sub && nw.sel_ring) bad = 1'b1;
    if (nw_src != SRC_MAIN && cur_src == SRC_MAIN && !cfg_q.force8) bad = 1'b1;
    if (nw_src == SRC_SUB && (!nw.force8 || !nw.sub_en || !stab_o[1])) bad = 1'b1;
    if (nw_src == SRC_RING && (!nw.ring_on || !stab_o[2])) bad = 1'b1;
    if (nw_src == SRC_MAIN && cur_src != SRC_MAIN && !stab_o[0]) bad = 1'b1;
    if (nw.main_stop && (nw_src == SRC_MAIN || cur_src == SRC_MAIN || act_q2[0])) bad = 1'b1;
    if (!nw.force8 && nw.div != cfg_q.div) bad = 1'b1;
  end

  always_comb begin
    cfg_d = cfg_q;
    err_d = err_q;
    if (err_clr) err_d = 1'b0;
    if (wr_en) begin
      if (bad) err_d = 1'b1;
      else     cfg_d = nw;
    end
  end

  always_ff @(posedge clk_ctl or negedge rst_c_n) begin
    if (!rst_c_n) begin
      cfg_q  <= CFG_RESET;
      err_q  <= 1'b0;
      act_q1 <= '0;
      act_q2 <= '0;
    end else begin
      cfg_q  <= cfg_d;
      err_q  <= err_d;
      act_q1 <= gate_w;
      act_q2 <= act_q1;
    end
  end

  assign run_o = {cfg_q.ring_on, cfg_q.sub_en, ~cfg_q.main_stop};
  assign req   = {cfg_q.sel_ring, cfg_q.sel_sub & ~cfg_q.sel_ring,
                  ~cfg_q.sel_sub & ~cfg_q.sel_ring};

  sck_glitchless_mux #(.N(NSRC), .RST_SEL(0)) u_mux (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .req(req), .gate_o(gate_w), .mclk(mclk)
  );

  sck_divider u_div (
    .mclk(mclk), .rst_n(src_rst_n[0]), .log2_i(div_log2(cfg_q)), .bclk(bclk)
  );

  always_comb begin
    case (act_q2)
      3'b001:  mode = (div_log2(cfg_q) == 3'd0) ? MD_HIGH : MD_MED;
      3'b010:  mode = MD_LOW;
      3'b100:  mode = MD_RING;
      default: mode = MD_SWITCH;
    endcase
  end

  assign mode_o = mode;
  assign cfg_o  = cfg_q;
  assign err_o  = err_q;
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk (
  input logic       clk_ctl,
  input logic       rst_n,
  input logic       err_clr,
  input logic [7:0] cfg_o,
  input logic       err_o,
  input logic [2:0] mode_o,
  input logic [2:0] gate
);
  AST_REJECT_HOLDS_CFG: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    $rose(err_o) |-> $stable(cfg_o)); // R11
  AST_ERR_STICKY: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    (err_o && !err_clr) |=> err_o); // R11
  AST_SUB_NEEDS_F8: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    cfg_o[3] |-> (cfg_o[0] && cfg_o[6])); // R4
  AST_SEL_EXCLUSIVE: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    !(cfg_o[3] && cfg_o[4])); // R5
  AST_STOP_OFF_MAIN: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    cfg_o[5] |-> (mode_o != 3'd0 && mode_o != 3'd1)); // R6
  AST_ONE_GATE: assert property (@(posedge clk_ctl) disable iff (!rst_n)
    $onehot0(gate)); // R12
endmodule

bind sysclk_ctrl sysclk_ctrl_chk u_chk (
  .clk_ctl(clk_ctl), .rst_n(rst_n), .err_clr(err_clr), .cfg_o(cfg_o),
  .err_o(err_o), .mode_o(mode_o), .gate(gate_w)
);

// File: tb/sim_sysclk_ctrl.sv
module sim_sysclk_ctrl;
  logic       clk_ctl = 1'b0, rst_n = 1'b1;
  logic       clk_main = 1'b0, clk_sub = 1'b0, clk_ring = 1'b0;
  logic       wr_en = 1'b0, err_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       bclk, err_o;
  logic [2:0] run_o, stab_o, mode_o;
  logic [7:0] cfg_o;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m_cfg = 8'h01;
  logic       m_err = 1'b0;
  logic       live = 1'b0;
  realtime    t_rise = 0, t_fall = 0, min_hi = 1.0e9, min_lo = 1.0e9;

  typedef struct { logic [7:0] cfg; logic err; string tag; } item_t;
  item_t sbq[$];

  sysclk_ctrl u0 (
    .clk_ctl(clk_ctl), .rst_n(rst_n), .clk_main(clk_main), .clk_sub(clk_sub),
    .clk_ring(clk_ring), .wr_en(wr_en), .wr_data(wr_data), .err_clr(err_clr),
    .bclk(bclk), .run_o(run_o), .stab_o(stab_o), .cfg_o(cfg_o), .err_o(err_o),
    .mode_o(mode_o)
  );

  always #10 clk_ctl = ~clk_ctl;
  always #4  clk_main = (run_o[0] === 1'b1) ? ~clk_main : 1'b0;
  always #30 clk_sub  = (run_o[1] === 1'b1) ? ~clk_sub  : 1'b0;
  always #7  clk_ring = (run_o[2] === 1'b1) ? ~clk_ring : 1'b0;

  always @(posedge bclk) begin
    if (live && ($realtime - t_fall) < min_lo) min_lo = $realtime - t_fall;
    t_rise = $realtime;
  end
  always @(negedge bclk) begin
    if (live && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
    t_fall = $realtime;
  end

  // scoreboard monitor
  always @(negedge clk_ctl) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      n_cmp++;
      if (cfg_o !== it.cfg || err_o !== it.err) begin
        n_bad++;
        $display("FAIL %s: cfg=%h err=%b expected cfg=%h err=%b",
                 it.tag, cfg_o, err_o, it.cfg, it.err);
      end
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic legal, input string tag);
    item_t it;
    @(negedge clk_ctl);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk_ctl); #1;
    wr_en = 1'b0;
    if (legal) m_cfg = d; else m_err = 1'b1;
    it.cfg = m_cfg; it.err = m_err; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic clr(input string tag);
    item_t it;
    @(negedge clk_ctl);
    err_clr = 1'b1;
    @(posedge clk_ctl); #1;
    err_clr = 1'b0;
    m_err = 1'b0;
    it.cfg = m_cfg; it.err = 1'b0; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_ctl);
    #1;
  endtask

  task automatic measure(input real exp, input string tag);
    realtime t0, p;
    repeat (2) @(posedge bclk);
    t0 = $realtime;
    @(posedge bclk);
    p = $realtime - t0;
    n_cmp++;
    if (p < exp - 0.5 || p > exp + 0.5) begin
      n_bad++;
      $display("FAIL %s: bclk period %0t expected %0.1f", tag, p, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (10) @(posedge clk_ctl);
    #1 rst_n = 1'b1;
    idle(40);
    @(negedge clk_ctl);
    check(cfg_o, 8'h01, "R1 cfg");
    check(err_o, 0, "R1 err");
    check(mode_o, 1, "R1 mode");
    check(run_o, 3'b001, "R1 run");
    live = 1'b1;
    measure(64.0, "R1 R2 reset /8");

    wr(8'h05, 1'b1, "R2 div under force8"); idle(20);
    measure(64.0, "R2 div ignored");
    wr(8'h04, 1'b1, "R3 clear force8"); idle(20);
    measure(32.0, "R3 /4");
    @(negedge clk_ctl); check(mode_o, 1, "R3 medium");

    wr(8'h02, 1'b0, "R8 div change while clear"); idle(5);
    measure(32.0, "R8 division unchanged");
    wr(8'h04, 1'b1, "R11 sticky over legal write");
    clr("R11 clear");

    wr(8'h05, 1'b1, "R3 set force8");
    wr(8'h01, 1'b1, "R3 stage div 00");
    wr(8'h02, 1'b0, "R8 clear force8 with new div");
    clr("R11 clear");
    wr(8'h00, 1'b1, "R3 /1"); idle(20);
    measure(8.0, "R3 /1");
    @(negedge clk_ctl); check(mode_o, 0, "R3 high");

    wr(8'h20, 1'b0, "R6 stop main while active");
    clr("R11 clear");

    wr(8'h40, 1'b1, "R10 enable sub");
    repeat (23) @(posedge clk_ctl);
    @(negedge clk_ctl); check(stab_o[1], 0, "R10 sub not yet stable");
    @(negedge clk_ctl); check(stab_o[1], 1, "R10 sub stable");

    wr(8'h49, 1'b0, "R9 leave main without force8");
    clr("R11 clear");
    wr(8'h41, 1'b1, "R9 set force8");
    wr(8'h49, 1'b1, "R4 select sub"); idle(80);
    @(negedge clk_ctl); check(mode_o, 2, "R4 low mode");
    measure(60.0, "R4 sub undivided");

    wr(8'h69, 1'b1, "R6 stop main"); idle(3);
    @(negedge clk_ctl); check(run_o[0], 0, "R6 main stopped");
    measure(60.0, "R6 still on sub");

    wr(8'h49, 1'b1, "R7 restart main");
    wr(8'h41, 1'b0, "R7 return before stable");
    clr("R11 clear");
    idle(30);
    wr(8'h41, 1'b1, "R7 return to main"); idle(60);
    @(negedge clk_ctl); check(mode_o, 1, "R7 medium on main");
    measure(64.0, "R9 return at /8");

    wr(8'hD1, 1'b0, "R5 ring not running");
    clr("R11 clear");
    wr(8'hC1, 1'b1, "R5 ring on"); idle(15);
    wr(8'hD9, 1'b0, "R5 both selects");
    clr("R11 clear");
    wr(8'hD1, 1'b1, "R5 select ring"); idle(60);
    @(negedge clk_ctl); check(mode_o, 3, "R5 ring mode");
    measure(112.0, "R5 ring /8");
    wr(8'hD5, 1'b1, "R5 stage div 10");
    wr(8'hD4, 1'b1, "R5 clear force8"); idle(30);
    measure(56.0, "R5 ring /4");

    idle(2);
    check((min_hi >= 3.9) ? 1 : 0, 1, "R12 min high phase");
    check((min_lo >= 3.9) ? 1 : 0, 1, "R12 min low phase");
    finish_run();
  end
endmodule